// File: doc/BRIEF.md
# Configurable CPLD Macrocell Register

This block models one output cell of a programmable logic device. It takes the result of a sum-of-products equation and turns it into either a registered bit or a combinational signal. The cell drives a pad value and an output enable, and it returns two feedback signals to the routing fabric. The register works as a D flip-flop or as a toggle flip-flop. Its clock is taken from one of four global clocks, each usable on either edge, or from one of two local control terms. Other local control terms clear or preset the register and gate the output enable. A global tri-state input can disable the output for board test.

The model runs on one system clock `clk`. The global clocks and the control terms are sampled on that clock, and a rising transition of the chosen source, seen between two samples, is a clock event for the cell. Clear and preset do not wait for a clock event. Every state change becomes visible one system clock after the input that caused it. The configuration inputs are static. The clock source and its polarity may be changed only while `rst` is high.

Top module: `cpld_macrocell`

## Requirements
- R1: While `rst` (synchronous, active high) is high, the stored bit becomes 0. In the registered modes `fb_cell` and `pad_out` are then 0.
- R2: `cfg_mode` = 1 is D mode. On a clock event the stored bit takes the value `sop_in` had at that system clock.
- R3: `cfg_mode` = 2 is toggle mode. On a clock event the stored bit inverts if `sop_in` is 1 and holds if `sop_in` is 0.
- R4: `cfg_mode` = 0 (and 3) is combinational. `fb_cell` and `pad_out` equal `sop_in` in the same cycle, with no clock edge involved.
- R5: `cfg_clk_sel` values 0 to 3 select `gclk[n]`. With `cfg_clk_fall` = 0 only a 0→1 transition is an event. With `cfg_clk_fall` = 1 only a 1→0 transition is an event.
- R6: `cfg_clk_sel` = 4 selects `ctrl_term[2]` and `cfg_clk_sel` = 5 selects `ctrl_term[3]`. Both are used on their rising transition, and the global clocks are then ignored.
- R7: `cfg_clk_sel` = 6 or 7 selects no clock. The stored bit then changes only through clear, preset or reset.
- R8: If `cfg_clr_en` = 1, `ctrl_term[0]` = 1 clears the stored bit at the next system clock. If `cfg_set_en` = 1, `ctrl_term[1]` = 1 presets it. When its enable is 0, each term has no effect.
- R9: Clear takes priority over preset, and both take priority over a clock event in the same cycle.
- R10: `cfg_oe_sel` 0..3 makes `pad_oe` follow `ctrl_term[2..5]`. A value of 4 enables the output always, and 5..7 disable it always.
- R11: When `cfg_gts_en` = 1 and `gts_n` = 0, `pad_oe` is 0 whatever `cfg_oe_sel` selects. When `cfg_gts_en` = 0, `gts_n` has no effect.
- R12: `fb_cell` carries the cell value (the stored bit or `sop_in`) whatever the state of the enable. `fb_pin` equals `pad_out` when `pad_oe` = 1 and equals `pad_in` when `pad_oe` = 0.
- R13: Without a clock event, clear or preset, the stored bit holds. A level that stays high on the clock source does not count as an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| sop_in | input | 1 | Sum-of-products equation result |
| gclk | input | GCLK_N | Global clock lines |
| ctrl_term | input | CT_N | Block control terms, bit n is term n |
| gts_n | input | 1 | Global tri-state, active low |
| pad_in | input | 1 | External value seen at the pin |
| cfg_mode | input | 2 | 0 comb, 1 D, 2 toggle, 3 comb |
| cfg_clk_sel | input | CSEL_W | Clock source select |
| cfg_clk_fall | input | 1 | Use falling edge of a global clock |
| cfg_clr_en | input | 1 | Enable clear from ctrl_term[0] |
| cfg_set_en | input | 1 | Enable preset from ctrl_term[1] |
| cfg_oe_sel | input | 3 | Output enable source select |
| cfg_gts_en | input | 1 | Let gts_n act on this cell |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad output enable |
| fb_cell | output | 1 | Feedback from before the output buffer |
| fb_pin | output | 1 | Feedback from the pin |

## Verification
The bench targets the edge-selection corners. It holds the clock source high across several samples, applies a rising edge while a falling one is configured, and moves global clocks while a control term or no source is selected. A design that is level-sensitive or takes the wrong polarity would capture in those cycles. The bench also asserts clear together with preset, and clear together with a clock edge, so a wrong priority shows as a 1 where 0 is due. It drives the terms with their enables off, so a design that ignores the enables would change the stored bit. Finally it pulls the global tri-state low while the output is forced on, and checks that the pin feedback switches to `pad_in` and the cell feedback does not.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int GCLK_N   = 4;
    localparam int CT_N     = 6;
    localparam int CT_CLK_A = 2;   // first control term usable as clock
    localparam int CT_CLK_B = 3;   // second control term usable as clock
    localparam int CT_OE_LO = 2;   // first control term usable as enable
    localparam int OE_CT_N  = 4;   // number of enable control terms

    typedef enum logic [1:0] {
        MODE_COMB = 2'd0,
        MODE_D    = 2'd1,
        MODE_T    = 2'd2,
        MODE_ALT  = 2'd3
    } mode_e;

    function automatic logic is_stored(input mode_e m);
        return (m == MODE_D) || (m == MODE_T);
    endfunction

    function automatic logic next_bit(input mode_e m, input logic q, input logic d);
        case (m)
            MODE_D:  return d;
            MODE_T:  return q ^ d;
            default: return q;
        endcase
    endfunction
endpackage

// File: rtl/mc_clk_event.sv
module mc_clk_event
    import mc_pkg::*;
#(
    parameter int GCLK_N_P = GCLK_N,
    localparam int CSEL_W  = $clog2(GCLK_N_P + 3)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [GCLK_N_P-1:0] gclk,
    input  logic                ct_clk_a,
    input  logic                ct_clk_b,
    input  logic [CSEL_W-1:0]   sel,
    input  logic                fall,
    output logic                ev
);
    logic src;
    logic src_q;

    always_comb begin
        src = 1'b0;
        for (int i = 0; i < GCLK_N_P; i++) begin
            if (sel == CSEL_W'(i)) src = gclk[i] ^ fall;
        end
        if (sel == CSEL_W'(GCLK_N_P))     src = ct_clk_a;
        if (sel == CSEL_W'(GCLK_N_P + 1)) src = ct_clk_b;
    end

    always_ff @(posedge clk) begin
        src_q <= src;
    end

    assign ev = src & ~src_q & ~rst;

    // R5: clock selection is static outside reset
    a_r5_cfg_static: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(sel) && $stable(fall)));
    // R13: no two consecutive events from a single source
    a_r13_no_level_event: assert property (@(posedge clk) disable iff (rst)
        ev |=> !ev);
endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  ev,
    input  logic  d,
    input  logic  clr,
    input  logic  set,
    output logic  q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (clr)  q <= 1'b0;
        else if (set)  q <= 1'b1;
        else if (ev)   q <= next_bit(mode, q, d);
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> !q);
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> !q);
    a_r8_preset: assert property (@(posedge clk) disable iff (rst)
        (set && !clr) |=> q);
    a_r2_d_capture: assert property (@(posedge clk) disable iff (rst)
        (ev && !clr && !set && mode == MODE_D) |=> (q == $past(d)));
    a_r3_toggle: assert property (@(posedge clk) disable iff (rst)
        (ev && !clr && !set && mode == MODE_T) |=> (q == ($past(q) ^ $past(d))));
    a_r13_hold: assert property (@(posedge clk) disable iff (rst)
        (!ev && !clr && !set) |=> $stable(q));
endmodule

// File: rtl/mc_oe.sv
module mc_oe
    import mc_pkg::*;
(
    input  logic [OE_CT_N-1:0] ct_oe,
    input  logic [2:0]         oe_sel,
    input  logic               gts_en,
    input  logic               gts_n,
    output logic               oe
);
    logic oe_raw;

    always_comb begin
        oe_raw = 1'b0;
        for (int i = 0; i < OE_CT_N; i++) begin
            if (oe_sel == 3'(i)) oe_raw = ct_oe[i];
        end
        if (oe_sel == 3'(OE_CT_N)) oe_raw = 1'b1;
    end

    assign oe = oe_raw & ~(gts_en & ~gts_n);
endmodule

// File: rtl/cpld_macrocell.sv
module cpld_macrocell
    import mc_pkg::*;
#(
    parameter int GCLK_N_P = GCLK_N,
    parameter int CT_N_P   = CT_N,
    localparam int CSEL_W  = $clog2(GCLK_N_P + 3)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sop_in,
    input  logic [GCLK_N_P-1:0] gclk,
    input  logic [CT_N_P-1:0]   ctrl_term,
    input  logic                gts_n,
    input  logic                pad_in,
    input  logic [1:0]          cfg_mode,
    input  logic [CSEL_W-1:0]   cfg_clk_sel,
    input  logic                cfg_clk_fall,
    input  logic                cfg_clr_en,
    input  logic                cfg_set_en,
    input  logic [2:0]          cfg_oe_sel,
    input  logic                cfg_gts_en,
    output logic                pad_out,
    output logic                pad_oe,
    output logic                fb_cell,
    output logic                fb_pin
);
    mode_e mode;
    logic  ev;
    logic  q;
    logic  cell_val;

    assign mode = mode_e'(cfg_mode);

    mc_clk_event #(.GCLK_N_P(GCLK_N_P)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .gclk     (gclk),
        .ct_clk_a (ctrl_term[CT_CLK_A]),
        .ct_clk_b (ctrl_term[CT_CLK_B]),
        .sel      (cfg_clk_sel),
        .fall     (cfg_clk_fall),
        .ev       (ev)
    );

    mc_store u_store (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .ev   (ev),
        .d    (sop_in),
        .clr  (cfg_clr_en & ctrl_term[0]),
        .set  (cfg_set_en & ctrl_term[1]),
        .q    (q)
    );

    mc_oe u_oe (
        .ct_oe  (ctrl_term[CT_OE_LO +: OE_CT_N]),
        .oe_sel (cfg_oe_sel),
        .gts_en (cfg_gts_en),
        .gts_n  (gts_n),
        .oe     (pad_oe)
    );

    assign cell_val = is_stored(mode) ? q : sop_in;
    assign pad_out  = cell_val;
    assign fb_cell  = cell_val;
    assign fb_pin   = pad_oe ? pad_out : pad_in;

    a_r4_comb_follow: assert property (@(posedge clk) disable iff (rst)
        !is_stored(mode) |-> (fb_cell == sop_in));
    a_r11_gts_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_gts_en && !gts_n) |-> !pad_oe);
    a_r10_forced_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_oe_sel > 3'd4) |-> !pad_oe);
    a_r12_pin_input: assert property (@(posedge clk) disable iff (rst)
        !pad_oe |-> (fb_pin == pad_in));
endmodule

// File: tb/tb_cpld_macrocell.sv
module tb_cpld_macrocell;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sop_in = 1'b0;
    logic [3:0] gclk = '0;
    logic [5:0] ctrl_term = '0;
    logic       gts_n = 1'b1;
    logic       pad_in = 1'b0;
    logic [1:0] cfg_mode = 2'd1;
    logic [2:0] cfg_clk_sel = 3'd0;
    logic       cfg_clk_fall = 1'b0;
    logic       cfg_clr_en = 1'b1;
    logic       cfg_set_en = 1'b1;
    logic [2:0] cfg_oe_sel = 3'd4;
    logic       cfg_gts_en = 1'b0;
    logic       pad_out, pad_oe, fb_cell, fb_pin;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cpld_macrocell dut (
        .clk(clk), .rst(rst), .sop_in(sop_in), .gclk(gclk),
        .ctrl_term(ctrl_term), .gts_n(gts_n), .pad_in(pad_in),
        .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
        .cfg_clk_fall(cfg_clk_fall), .cfg_clr_en(cfg_clr_en),
        .cfg_set_en(cfg_set_en), .cfg_oe_sel(cfg_oe_sel),
        .cfg_gts_en(cfg_gts_en), .pad_out(pad_out), .pad_oe(pad_oe),
        .fb_cell(fb_cell), .fb_pin(fb_pin)
    );

    // vector: {gclk[0], sop_in, ctrl_term[0], ctrl_term[1], expected stored bit}
    localparam logic [4:0] VEC [12] = '{
        5'b0_1_0_0_0,  // R13 no edge
        5'b1_1_0_0_1,  // R2 rising capture
        5'b1_0_0_0_1,  // R13 high level, no event
        5'b0_0_0_0_1,  // R5 falling ignored
        5'b1_0_0_0_0,  // R2 capture 0
        5'b0_1_0_1_1,  // R8 preset
        5'b0_0_0_0_1,  // R13 hold
        5'b0_0_1_0_0,  // R8 clear
        5'b0_0_1_1_0,  // R9 clear beats preset
        5'b1_1_0_0_1,  // R2 capture 1
        5'b0_0_1_0_0,  // R8 clear
        5'b1_1_1_0_0   // R9 clear beats edge
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic configure(input logic [1:0] m, input logic [2:0] cs,
                             input logic f, input logic ce, input logic se);
        rst = 1'b1;
        cfg_mode = m; cfg_clk_sel = cs; cfg_clk_fall = f;
        cfg_clr_en = ce; cfg_set_en = se;
        step();
        step();
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        configure(2'd1, 3'd0, 1'b0, 1'b1, 1'b1);
        chk(fb_cell, 1'b0, "R1 reset state");
        chk(pad_oe, 1'b1, "R10 always on");

        for (int i = 0; i < 12; i++) begin
            gclk[0] = VEC[i][4]; sop_in = VEC[i][3];
            ctrl_term[0] = VEC[i][2]; ctrl_term[1] = VEC[i][1];
            step();
            chk(pad_out, VEC[i][0], $sformatf("R2/R8/R9/R13 vector %0d", i));
        end
        ctrl_term[1:0] = 2'b10; gclk[0] = 1'b0;
        step();
        ctrl_term[1:0] = 2'b00;
        chk(fb_cell, 1'b1, "R8 preset before reset");
        rst = 1'b1; step(); rst = 1'b0;
        chk(fb_cell, 1'b0, "R1 reset clears");

        // R5 falling edge polarity on gclk[1]
        configure(2'd1, 3'd1, 1'b1, 1'b1, 1'b1);
        sop_in = 1'b1; gclk[1] = 1'b1; step();
        chk(fb_cell, 1'b0, "R5 rising ignored in fall mode");
        gclk[1] = 1'b0; step();
        chk(fb_cell, 1'b1, "R5 falling captures");

        // R6 control-term clock ctrl_term[3]
        configure(2'd1, 3'd5, 1'b0, 1'b1, 1'b1);
        sop_in = 1'b1; gclk = 4'hF; step();
        chk(fb_cell, 1'b0, "R6 global clocks ignored");
        ctrl_term[3] = 1'b1; step();
        chk(fb_cell, 1'b1, "R6 term rising captures");
        sop_in = 1'b0; step();
        chk(fb_cell, 1'b1, "R6 term high level holds");
        ctrl_term[3] = 1'b0; step();
        ctrl_term[3] = 1'b1; step();
        chk(fb_cell, 1'b0, "R6 second rising captures");
        ctrl_term[3] = 1'b0; gclk = 4'h0;

        // R7 no clock source
        configure(2'd1, 3'd6, 1'b0, 1'b1, 1'b1);
        sop_in = 1'b1;
        for (int k = 0; k < 4; k++) begin
            gclk = gclk ^ 4'hF; ctrl_term[3:2] = ctrl_term[3:2] ^ 2'b11;
            step();
        end
        chk(fb_cell, 1'b0, "R7 no clock holds");
        gclk = 4'h0; ctrl_term = '0;

        // R3 toggle mode on gclk[2]
        configure(2'd2, 3'd2, 1'b0, 1'b1, 1'b1);
        sop_in = 1'b1; gclk[2] = 1'b1; step();
        chk(fb_cell, 1'b1, "R3 toggle up");
        gclk[2] = 1'b0; step();
        sop_in = 1'b0; gclk[2] = 1'b1; step();
        chk(fb_cell, 1'b1, "R3 hold on zero");
        gclk[2] = 1'b0; step();
        sop_in = 1'b1; gclk[2] = 1'b1; step();
        chk(fb_cell, 1'b0, "R3 toggle down");
        gclk[2] = 1'b0;

        // R4 combinational mode
        configure(2'd0, 3'd6, 1'b0, 1'b1, 1'b1);
        sop_in = 1'b1; #1;
        chk(pad_out, 1'b1, "R4 comb high");
        sop_in = 1'b0; #1;
        chk(fb_cell, 1'b0, "R4 comb low");
        @(negedge clk);

        // R8 enables off
        configure(2'd1, 3'd6, 1'b0, 1'b0, 1'b0);
        ctrl_term[1] = 1'b1; step();
        chk(fb_cell, 1'b0, "R8 preset disabled");
        ctrl_term[1] = 1'b0;
        configure(2'd1, 3'd6, 1'b0, 1'b0, 1'b1);
        ctrl_term[1] = 1'b1; step();
        ctrl_term[1] = 1'b0; ctrl_term[0] = 1'b1; step();
        chk(fb_cell, 1'b1, "R8 clear disabled");
        ctrl_term[0] = 1'b0;

        // R10 enable selection (stored bit is 1)
        cfg_oe_sel = 3'd2; ctrl_term[4] = 1'b1; #1;
        chk(pad_oe, 1'b1, "R10 follows term 4 high");
        ctrl_term[4] = 1'b0; #1;
        chk(pad_oe, 1'b0, "R10 follows term 4 low");
        cfg_oe_sel = 3'd0; ctrl_term[2] = 1'b1; #1;
        chk(pad_oe, 1'b1, "R10 follows term 2");
        ctrl_term[2] = 1'b0;
        cfg_oe_sel = 3'd5; #1;
        chk(pad_oe, 1'b0, "R10 forced off");

        // R12 feedback paths
        pad_in = 1'b0; #1;
        chk(fb_pin, 1'b0, "R12 pin reads pad_in 0");
        pad_in = 1'b1; #1;
        chk(fb_pin, 1'b1, "R12 pin reads pad_in 1");
        chk(fb_cell, 1'b1, "R12 cell feedback while off");
        cfg_oe_sel = 3'd4; pad_in = 1'b0; #1;
        chk(fb_pin, 1'b1, "R12 pin reads driven value");

        // R11 global tri-state
        cfg_gts_en = 1'b1; gts_n = 1'b0; #1;
        chk(pad_oe, 1'b0, "R11 gts forces off");
        chk(fb_pin, 1'b0, "R12 pin reads pad_in under gts");
        gts_n = 1'b1; #1;
        chk(pad_oe, 1'b1, "R11 gts released");
        cfg_gts_en = 1'b0; gts_n = 1'b0; #1;
        chk(pad_oe, 1'b1, "R11 gts disabled");
        gts_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule